// File: doc/BRIEF.md
# Chromatic Sweep Square-Wave Source

This block produces a test tone for an audio output path: a square wave whose pitch climbs one semitone at a time through three octaves and then returns to the bottom. It sits in the master audio clock domain. It produces one signed 16-bit sample each time the sample strobe is asserted, nominally at 24 kHz, and places the same sample on the left and right outputs.

The pitch comes from a phase accumulator. Each strobe adds a per-note increment to it, and its top bit selects the polarity of the output. The increments come from a twelve-entry semitone table for the lowest octave, doubled by shifting for each octave above it. A duration timer counts samples within the current note. When the timer expires, the design moves to the next note and clears the accumulator. The note length is an input, and a zero on that input selects the default quarter-second length.

Top module: `note_sweep_gen`

## Requirements
- R1: After reset, `left` and `right` read 0 until the first sample strobe.
- R2: Every sample is +8192 or -8192 in 16-bit two's complement. It is +8192 when bit 31 of the phase in use is 0 and -8192 when that bit is 1.
- R3: The phase in use for the j-th sample of a note (j counted from 0) is j times the note's increment, modulo 2^32. The phase restarts at zero on every note change, so the first sample of each note is +8192.
- R4: Note n = 12*o + s (o is the octave 0..2, s is the semitone 0..11, n = 0 is the lowest C) uses the increment round(130.8128 * 2^(s/12) * 2^32 / 24000) shifted left by o bits.
- R5: Notes advance upward by one, 0 to 35, and note 35 is followed by note 0.
- R6: A note ends on the strobe at which its sample count j satisfies j >= L-1, where L is the effective length. A length lowered in mid-note therefore ends the note at the next strobe.
- R7: `note_len` = 0 selects an effective length of 6000 samples. Any other value is used as given.
- R8: Without a strobe, the outputs, the note position and the phase do not change.
- R9: `left` and `right` carry the same sample at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle pulse requesting the next sample |
| note_len | input | 16 | Samples per note; 0 selects the default length |
| left | output | 16 | Signed left-channel sample |
| right | output | 16 | Signed right-channel sample |

## Verification
The bench compares every strobed sample with a reference model. The model derives each increment from a real-valued pitch formula, so a wrong table entry or a missing octave shift shows up as a flip at the wrong sample. Running through all 36 notes and past the wrap catches a sequencer that stalls at the top or restarts at note 1. It also catches a design that carries phase across note boundaries, because a note would then begin on a negative sample. Lengths of 1 and 0 test two things: a timer that stays stuck when every note lasts one sample, and a default that is never substituted. Shortening the length in mid-note exposes an equality compare, which would run for 65536 samples before ending the note. Gaps between strobes reveal a design that advances on the clock rather than on the strobe.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

   localparam int SEMIS = 12;
   localparam int BASE_W = 32;

   // increments of the lowest octave at a 32-bit phase and 24 kHz sampling
   function automatic logic [BASE_W-1:0] semi_base(input logic [3:0] s);
      case (s)
         4'd0:    semi_base = 32'd23409859;
         4'd1:    semi_base = 32'd24801883;
         4'd2:    semi_base = 32'd26276679;
         4'd3:    semi_base = 32'd27839171;
         4'd4:    semi_base = 32'd29494575;
         4'd5:    semi_base = 32'd31248413;
         4'd6:    semi_base = 32'd33106541;
         4'd7:    semi_base = 32'd35075158;
         4'd8:    semi_base = 32'd37160835;
         4'd9:    semi_base = 32'd39370534;
         4'd10:   semi_base = 32'd41711627;
         4'd11:   semi_base = 32'd44191930;
         default: semi_base = '0;
      endcase
   endfunction

endpackage

// File: rtl/nsg_pitch_rom.sv
module nsg_pitch_rom #(
   parameter int PHASE_W = 32,
   parameter int OCT_W   = 2
) (
   input  logic [3:0]         semi,
   input  logic [OCT_W-1:0]   oct,
   output logic [PHASE_W-1:0] inc
);
   import nsg_pkg::*;

   logic [BASE_W-1:0]  base;
   logic [PHASE_W-1:0] base_ext;

   assign base = semi_base(semi);

   generate
      if (PHASE_W >= BASE_W) begin : g_wide
         assign base_ext = PHASE_W'(base) << (PHASE_W - BASE_W);
      end else begin : g_narrow
         assign base_ext = PHASE_W'(base >> (BASE_W - PHASE_W));
      end
   endgenerate

   assign inc = base_ext << oct;

endmodule

// File: rtl/nsg_sequencer.sv
module nsg_sequencer #(
   parameter int LEN_W       = 16,
   parameter int NUM_OCTAVES = 3,
   parameter int DEFAULT_LEN = 6000,
   parameter int OCT_W       = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stb,
   input  logic [LEN_W-1:0]   note_len,
   output logic [3:0]         semi,
   output logic [OCT_W-1:0]   oct,
   output logic [LEN_W-1:0]   timer,
   output logic               note_end
);
   import nsg_pkg::*;

   logic [LEN_W-1:0] len_eff;
   logic             last;
   logic [3:0]       semi_q;
   logic [OCT_W-1:0] oct_q;
   logic [LEN_W-1:0] timer_q;

   assign len_eff  = (note_len == '0) ? LEN_W'(DEFAULT_LEN) : note_len;
   assign last     = (timer_q >= len_eff - LEN_W'(1));
   assign note_end = stb & last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         semi_q  <= '0;
         oct_q   <= '0;
         timer_q <= '0;
      end else if (stb) begin
         if (last) begin
            timer_q <= '0;
            if (semi_q == 4'(SEMIS - 1)) begin
               semi_q <= '0;
               oct_q  <= (oct_q == OCT_W'(NUM_OCTAVES - 1)) ? '0 : oct_q + OCT_W'(1);
            end else begin
               semi_q <= semi_q + 4'd1;
            end
         end else begin
            timer_q <= timer_q + LEN_W'(1);
         end
      end
   end

   assign semi  = semi_q;
   assign oct   = oct_q;
   assign timer = timer_q;

endmodule

// File: rtl/nsg_square_osc.sv
module nsg_square_osc #(
   parameter int PHASE_W   = 32,
   parameter int SAMPLE_W  = 16,
   parameter int AMPLITUDE = 8192
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       stb,
   input  logic                       restart,
   input  logic [PHASE_W-1:0]         inc,
   output logic signed [SAMPLE_W-1:0] sample,
   output logic [PHASE_W-1:0]         phase
);
   localparam logic signed [SAMPLE_W-1:0] POS_LVL = SAMPLE_W'(AMPLITUDE);
   localparam logic signed [SAMPLE_W-1:0] NEG_LVL = SAMPLE_W'(-AMPLITUDE);

   logic [PHASE_W-1:0]         acc_q;
   logic signed [SAMPLE_W-1:0] sample_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= '0;
         sample_q <= '0;
      end else if (stb) begin
         sample_q <= acc_q[PHASE_W-1] ? NEG_LVL : POS_LVL;
         acc_q    <= restart ? '0 : acc_q + inc;
      end
   end

   assign sample = sample_q;
   assign phase  = acc_q;

endmodule

// File: rtl/note_sweep_gen.sv
module note_sweep_gen #(
   parameter int SAMPLE_W    = 16,
   parameter int PHASE_W     = 32,
   parameter int NUM_OCTAVES = 3,
   parameter int LEN_W       = 16,
   parameter int DEFAULT_LEN = 6000,
   parameter int AMPLITUDE   = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_stb,
   input  logic [LEN_W-1:0]    note_len,
   output logic [SAMPLE_W-1:0] left,
   output logic [SAMPLE_W-1:0] right
);
   import nsg_pkg::*;

   localparam int OCT_W     = (NUM_OCTAVES > 1) ? $clog2(NUM_OCTAVES) : 1;
   localparam int NUM_NOTES = SEMIS * NUM_OCTAVES;
   localparam int NOTE_W    = $clog2(NUM_NOTES);

   generate
      if (SAMPLE_W < 2) begin : g_bad_sw
         $error("SAMPLE_W must be at least 2");
      end
      if (AMPLITUDE <= 0 || AMPLITUDE >= (1 << (SAMPLE_W - 1))) begin : g_bad_amp
         $error("AMPLITUDE must fit in a signed sample");
      end
      if (PHASE_W < 16) begin : g_bad_pw
         $error("PHASE_W below 16 gives too coarse a pitch");
      end
      if (NUM_OCTAVES < 1 || NUM_OCTAVES > 6) begin : g_bad_oct
         $error("NUM_OCTAVES must be 1 to 6");
      end
      if (DEFAULT_LEN < 1 || DEFAULT_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("DEFAULT_LEN must fit in LEN_W bits");
      end
   endgenerate

   logic [3:0]                semi_q;
   logic [OCT_W-1:0]          oct_q;
   logic [LEN_W-1:0]          timer_q;
   logic                      note_end;
   logic [PHASE_W-1:0]        inc;
   logic [PHASE_W-1:0]        acc_q;
   logic signed [SAMPLE_W-1:0] sample_q;
   logic [NOTE_W-1:0]         note_idx;

   nsg_sequencer #(
      .LEN_W(LEN_W), .NUM_OCTAVES(NUM_OCTAVES),
      .DEFAULT_LEN(DEFAULT_LEN), .OCT_W(OCT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .stb(sample_stb), .note_len(note_len),
      .semi(semi_q), .oct(oct_q), .timer(timer_q), .note_end(note_end)
   );

   nsg_pitch_rom #(.PHASE_W(PHASE_W), .OCT_W(OCT_W)) u_rom (
      .semi(semi_q), .oct(oct_q), .inc(inc)
   );

   nsg_square_osc #(
      .PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .AMPLITUDE(AMPLITUDE)
   ) u_osc (
      .clk(clk), .rst_n(rst_n), .stb(sample_stb), .restart(note_end),
      .inc(inc), .sample(sample_q), .phase(acc_q)
   );

   assign note_idx = NOTE_W'(oct_q) * NOTE_W'(SEMIS) + NOTE_W'(semi_q);

   assign left  = sample_q;
   assign right = sample_q;

endmodule

// File: rtl/note_sweep_gen_chk.sv
module note_sweep_gen_chk #(
   parameter int SAMPLE_W    = 16,
   parameter int PHASE_W     = 32,
   parameter int LEN_W       = 16,
   parameter int DEFAULT_LEN = 6000,
   parameter int AMPLITUDE   = 8192,
   parameter int NUM_NOTES   = 36,
   parameter int NOTE_W      = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                stb,
   input logic [LEN_W-1:0]    note_len,
   input logic [SAMPLE_W-1:0] left,
   input logic [SAMPLE_W-1:0] right,
   input logic [NOTE_W-1:0]   note,
   input logic [PHASE_W-1:0]  acc,
   input logic [LEN_W-1:0]    timer
);
   logic [LEN_W-1:0] len_eff;
   assign len_eff = (note_len == '0) ? LEN_W'(DEFAULT_LEN) : note_len;

   // R2
   level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (left == '0) || (left == SAMPLE_W'(AMPLITUDE)) || (left == SAMPLE_W'(-AMPLITUDE)));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(left) && $stable(note) && $stable(acc) && $stable(timer));

   // R5
   note_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      note < NOTE_W'(NUM_NOTES));

   // R5
   note_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (note != $past(note)) |->
         ((note == $past(note) + NOTE_W'(1)) ||
          (($past(note) == NOTE_W'(NUM_NOTES - 1)) && (note == '0))));

   // R3
   acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (note != $past(note)) |-> (acc == '0));

   // R6
   timer_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && (timer >= len_eff - LEN_W'(1))) |=> (timer == '0));

   // R9
   chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left == right);

endmodule

bind note_sweep_gen note_sweep_gen_chk #(
   .SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W), .LEN_W(LEN_W),
   .DEFAULT_LEN(DEFAULT_LEN), .AMPLITUDE(AMPLITUDE),
   .NUM_NOTES(NUM_NOTES), .NOTE_W(NOTE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stb(sample_stb), .note_len(note_len),
   .left(left), .right(right), .note(note_idx), .acc(acc_q), .timer(timer_q)
);

// File: tb/note_sweep_gen_bench.sv
module note_sweep_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_stb = 1'b0;
   logic [15:0] note_len = 16'd100;
   logic [15:0] left, right;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   int m_note = 0;
   int m_j = 0;

   always #5 clk = ~clk;

   note_sweep_gen u_note_sweep_gen (
      .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .note_len(note_len),
      .left(left), .right(right)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
      end
   endtask

   // R4: increment from the real pitch formula
   function automatic longint exp_inc(input int n);
      real f;
      longint b;
      f = 130.8127826502993 * $pow(2.0, (n % 12) / 12.0);
      b = longint'($rtoi(f * 4294967296.0 / 24000.0 + 0.5));
      return b << (n / 12);
   endfunction

   function automatic logic [15:0] exp_sample(input int n, input int j);
      longint ph;
      ph = (longint'(j) * exp_inc(n)) & 64'hFFFF_FFFF;
      return ph[31] ? 16'(-8192) : 16'(8192);
   endfunction

   function automatic int len_eff();
      return (note_len == 16'd0) ? 6000 : int'(note_len);
   endfunction

   // one strobe; compares both channels with the model (R2 R3 R4 R5 R6 R9)
   task automatic strobe(input string req);
      logic [15:0] e;
      @(negedge clk) sample_stb = 1'b1;
      @(negedge clk) sample_stb = 1'b0;
      e = exp_sample(m_note, m_j);
      check(req, left, e);
      check({req, " R9"}, right, left);
      if (m_j >= len_eff() - 1) begin
         m_j = 0;
         m_note = (m_note == 35) ? 0 : m_note + 1;
      end else begin
         m_j++;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_note = 0; m_j = 0;
      repeat (3) @(negedge clk);
      check("R1 left after reset", left, 16'd0);
      check("R1 right after reset", right, 16'd0);
      strobe("R3 first sample");
      check("R2 first sample is +8192", left, 16'd8192);
   endtask

   // full sweep plus wrap back to the lowest note (R4 R5)
   task automatic t_sweep();
      note_len = 16'd100;
      for (int i = 0; i < 36 * 100 + 150; i++) strobe("R4 R5 sweep");
   endtask

   // gaps between strobes must freeze everything (R8)
   task automatic t_hold();
      logic [15:0] held;
      held = left;
      repeat (25) @(negedge clk);
      check("R8 held left", left, held);
      check("R8 held right", right, held);
      for (int i = 0; i < 60; i++) begin
         strobe("R8 resume");
         repeat (3) @(negedge clk);
      end
   endtask

   // length one: every note is a single positive sample (R6 R3)
   task automatic t_len_one();
      note_len = 16'd1;
      for (int i = 0; i < 40; i++) begin
         strobe("R6 len one");
         check("R3 note start positive", left, 16'd8192);
      end
      note_len = 16'd100;
      for (int i = 0; i < 150; i++) strobe("R6 after len one");
   endtask

   // shrinking the length mid-note ends it at once (R6)
   task automatic t_shrink();
      note_len = 16'd200;
      while (m_j != 0) strobe("R6 align");
      for (int i = 0; i < 50; i++) strobe("R6 long note");
      note_len = 16'd10;
      strobe("R6 last of shrunk note");
      strobe("R6 next note start");
      check("R6 new note starts positive", left, 16'd8192);
      for (int i = 0; i < 100; i++) strobe("R6 short notes");
   endtask

   // zero length selects 6000 samples (R7)
   task automatic t_default();
      note_len = 16'd0;
      while (m_j != 0) strobe("R7 align");
      for (int i = 0; i < 6000 + 300; i++) strobe("R7 default length");
   endtask

   initial begin
      t_reset();
      t_sweep();
      t_hold();
      t_len_one();
      t_shrink();
      t_default();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule